// File: doc/BRIEF.md
# Dual-Lane Saturating Halfword Subtractor

This pipelined execution unit splits each of two 32-bit source words into two signed 16-bit lanes. It subtracts the second source from the first, lane by lane. Each lane difference is formed at full precision and then clamped to the signed 16-bit range. The two clamped results are packed back into a 32-bit word. That word leaves the unit as a register-file write request: data, destination index and a write enable.

An operation is issued by raising a valid strobe in a cycle, together with the operands, a destination index and a predicate word. Only bit 0 of the predicate decides whether the write is committed. Callers with no predicate tie it to 1. The request appears exactly two cycles after issue, and a new operation may be issued in every cycle.

Top module: `dsub_dual_sat`

## Requirements
- R1: The low lane uses bits 15:0 and the high lane uses bits 31:16 of both sources. Each lane's result lands in the same bit positions of `wr_data_o`, and one lane never affects the other.
- R2: When the signed lane difference a − b lies in [−32768, 32767], the lane result equals that difference exactly.
- R3: A lane difference above 32767 yields 0x7fff in that lane.
- R4: A lane difference below −32768 yields 0x8000 in that lane.
- R5: An issue with `guard_i[0]`=1 produces `wr_en_o`=1. An issue with `guard_i[0]`=0 produces no write enable.
- R6: The write request appears on the outputs two clock cycles after the issuing cycle, and `wr_idx_o` equals the `dest_idx_i` of that issue.
- R7: Operations issued in consecutive cycles each produce their own write request, in consecutive cycles and in issue order.
- R8: While `rst_ni` is low, and after it is released until a committed issue reaches the output, `wr_en_o` is 0. An operation in flight when reset is asserted is discarded.
- R9: Bits 31:1 of `guard_i` have no effect on the write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation issued this cycle |
| src_a_i | input | 32 | Minuend, two signed halfword lanes |
| src_b_i | input | 32 | Subtrahend, two signed halfword lanes |
| dest_idx_i | input | 5 | Destination register index |
| guard_i | input | 32 | Predicate word; bit 0 commits the write |
| wr_en_o | output | 1 | Write request valid |
| wr_idx_o | output | 5 | Destination register index of the request |
| wr_data_o | output | 32 | Packed saturated lane differences |

## Verification
The embedded properties compare outputs against inputs sampled two edges earlier. They therefore assume that `guard_i`, `issue_valid_i`, `dest_idx_i` and the source sign bits are driven to known levels in every cycle after reset, including idle cycles. They also only judge cycles at least two edges past reset release. The bench honours this by driving every input from a falling-edge task in each cycle and holding them at zero during reset. It streams a sweep of lane corner values (zero, ±1, both extremes and mid-range values) back to back. The high lane is drawn from a shifted index of the same table, so the two lanes carry different pairs within one word.

// File: rtl/dsub_pkg.sv
package dsub_pkg;
  parameter int unsigned DSUB_LANE_W = 16;
  parameter int unsigned DSUB_LANES  = 2;
  parameter int unsigned DSUB_IDX_W  = 5;

  // control bits travelling alongside the data in stage 1
  typedef struct packed {
    logic vld;
    logic grd;
  } dsub_ctl_t;
endpackage

// File: rtl/dsub_lane_diff.sv
module dsub_lane_diff #(
  parameter int unsigned LANE_W = 16,
  localparam int unsigned DIFF_W = LANE_W + 1
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [DIFF_W-1:0] diff_o
);
  logic signed [DIFF_W-1:0] a_ext, b_ext;

  always_comb begin
    a_ext  = {a_i[LANE_W-1], a_i};
    b_ext  = {b_i[LANE_W-1], b_i};
    diff_o = a_ext - b_ext;
  end
endmodule

// File: rtl/dsub_lane_clip.sv
module dsub_lane_clip #(
  parameter int unsigned LANE_W = 16,
  localparam int unsigned DIFF_W = LANE_W + 1
) (
  input  logic [DIFF_W-1:0] diff_i,
  output logic [LANE_W-1:0] res_o
);
  localparam logic [LANE_W-1:0] MaxPos = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] MaxNeg = {1'b1, {(LANE_W-1){1'b0}}};

  // overflow when the two top bits disagree; top bit is the true sign
  always_comb begin
    if (diff_i[DIFF_W-1] == diff_i[DIFF_W-2]) res_o = diff_i[LANE_W-1:0];
    else if (diff_i[DIFF_W-1])                res_o = MaxNeg;
    else                                      res_o = MaxPos;
  end
endmodule

// File: rtl/dsub_dual_sat.sv
module dsub_dual_sat
  import dsub_pkg::*;
#(
  parameter int unsigned LANE_W = DSUB_LANE_W,
  parameter int unsigned LANES  = DSUB_LANES,
  parameter int unsigned IDX_W  = DSUB_IDX_W,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned DIFF_W = LANE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IDX_W-1:0]  dest_idx_i,
  input  logic [DATA_W-1:0] guard_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [LANES-1:0][DIFF_W-1:0] diff_d, diff_q;
  logic [LANES-1:0][LANE_W-1:0] clip_d, data_q;
  dsub_ctl_t                    s1_ctl_q;
  logic [IDX_W-1:0]             s1_idx_q, s2_idx_q;
  logic                         s2_en_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dsub_lane_diff #(.LANE_W(LANE_W)) u_diff (
      .a_i   (src_a_i[l*LANE_W +: LANE_W]),
      .b_i   (src_b_i[l*LANE_W +: LANE_W]),
      .diff_o(diff_d[l])
    );
    dsub_lane_clip #(.LANE_W(LANE_W)) u_clip (
      .diff_i(diff_q[l]),
      .res_o (clip_d[l])
    );
  end

  // stage 1: full-precision differences
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_ctl_q <= '0;
      s1_idx_q <= '0;
      diff_q   <= '0;
    end else begin
      s1_ctl_q.vld <= issue_valid_i;
      s1_ctl_q.grd <= guard_i[0];
      if (issue_valid_i) begin
        s1_idx_q <= dest_idx_i;
        diff_q   <= diff_d;
      end
    end
  end

  // stage 2: clipped result and write request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_en_q  <= 1'b0;
      s2_idx_q <= '0;
      data_q   <= '0;
    end else begin
      s2_en_q <= s1_ctl_q.vld & s1_ctl_q.grd;
      if (s1_ctl_q.vld) begin
        s2_idx_q <= s1_idx_q;
        data_q   <= clip_d;
      end
    end
  end

  assign wr_en_o   = s2_en_q;
  assign wr_idx_o  = s2_idx_q;
  assign wr_data_o = data_q;

  // edges since reset release, saturating at the pipeline depth
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_guard_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && !$past(guard_i[0], 2)) |-> !wr_en_o);

  assert_commit_lat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && $past(issue_valid_i && guard_i[0], 2))
      |-> (wr_en_o && wr_idx_o == $past(dest_idx_i, 2)));

  assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd2 || !$past(issue_valid_i, 2)) |-> !wr_en_o);

  for (genvar l = 0; l < LANES; l++) begin : g_sign_chk
    localparam int unsigned Msb = (l + 1) * LANE_W - 1;
    // non-negative minus negative can never come out negative
    assert_pos_clip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2 && wr_en_o && $past(!src_a_i[Msb] && src_b_i[Msb], 2))
        |-> !wr_data_o[Msb]);
    // negative minus non-negative is always negative
    assert_neg_clip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2 && wr_en_o && $past(src_a_i[Msb] && !src_b_i[Msb], 2))
        |-> wr_data_o[Msb]);
  end
endmodule

// File: tb/dsub_dual_sat_bench.sv
`timescale 1ns/1ps
module dsub_dual_sat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] a = '0, b = '0, grd = '0;
  logic [4:0]  idx = '0;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsub_dual_sat u_dsub_dual_sat (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(vld),
    .src_a_i(a), .src_b_i(b), .dest_idx_i(idx), .guard_i(grd),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  // expected history: [0] issued one negedge ago, [1] two ago
  logic        h_en [2];
  logic        h_vld[2];
  logic [31:0] h_data[2], h_grd[2];
  logic [4:0]  h_idx[2];
  int          h_tag[2];

  function automatic logic [15:0] ref_lane(input logic [15:0] x, input logic [15:0] y,
                                           output int kind);
    int d;
    d = int'($signed(x)) - int'($signed(y));
    if (d > 32767)       begin kind = 3; return 16'h7fff; end
    else if (d < -32768) begin kind = 4; return 16'h8000; end
    kind = 2;
    return d[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 2; i++) begin
      h_en[i] = 0; h_vld[i] = 0; h_data[i] = '0; h_grd[i] = '0; h_idx[i] = '0; h_tag[i] = 0;
    end
  endtask

  // one falling edge: check what was issued two cycles back, then drive the next issue
  task automatic step(input logic v, input logic [31:0] x, input logic [31:0] y,
                      input logic [4:0] d, input logic [31:0] g);
    int k0, k1;
    logic [31:0] e;
    @(negedge clk);
    if (h_grd[1][0] == 1'b0 && h_grd[1][31:1] != '0)
      chk(wr_en == 1'b0, "R9 upper guard bits", {31'b0, wr_en}, 32'h0);
    else
      chk(wr_en == h_en[1], "R5/R7 write enable", {31'b0, wr_en}, {31'b0, h_en[1]});
    if (h_en[1]) begin
      chk(wr_idx == h_idx[1], "R6 dest index", {27'b0, wr_idx}, {27'b0, h_idx[1]});
      e = h_data[1];
      case (h_tag[1] % 10)
        3:       chk(wr_data[15:0] == e[15:0], "R3 low lane", wr_data, e);
        4:       chk(wr_data[15:0] == e[15:0], "R4 low lane", wr_data, e);
        default: chk(wr_data[15:0] == e[15:0], "R2 low lane", wr_data, e);
      endcase
      case (h_tag[1] / 10)
        3:       chk(wr_data[31:16] == e[31:16], "R1/R3 high lane", wr_data, e);
        4:       chk(wr_data[31:16] == e[31:16], "R1/R4 high lane", wr_data, e);
        default: chk(wr_data[31:16] == e[31:16], "R1/R2 high lane", wr_data, e);
      endcase
    end
    h_en[1] = h_en[0]; h_vld[1] = h_vld[0]; h_data[1] = h_data[0];
    h_grd[1] = h_grd[0]; h_idx[1] = h_idx[0]; h_tag[1] = h_tag[0];
    h_vld[0] = v; h_grd[0] = v ? g : 32'h0; h_idx[0] = d;
    h_en[0] = v & g[0];
    h_data[0][15:0]  = ref_lane(x[15:0], y[15:0], k0);
    h_data[0][31:16] = ref_lane(x[31:16], y[31:16], k1);
    h_tag[0] = k1 * 10 + k0;
    vld = v; a = x; b = y; idx = d; grd = g;
  endtask

  localparam int NC = 9;
  logic [15:0] corner [NC];

  initial begin
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7fff;
    corner[3] = 16'h8000; corner[4] = 16'h8001; corner[5] = 16'hffff;
    corner[6] = 16'h1234; corner[7] = 16'h4000; corner[8] = 16'hc000;
    clear_hist();
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R8 in reset", {31'b0, wr_en}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // idle after reset
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, '0);
    // fixed vectors
    step(1'b1, 32'h12340032, 32'h00010002, 5'd6,  32'h1);
    step(1'b1, 32'h80000001, 32'h00018001, 5'd9,  32'h1);
    step(1'b1, 32'h00018001, 32'h80010002, 5'd25, 32'h1);
    step(1'b1, 32'h12340032, 32'h00010002, 5'd7,  32'h0);
    step(1'b1, 32'h12340032, 32'h00010002, 5'd10, 32'hfffffffe);
    step(1'b1, 32'h12340032, 32'h00010002, 5'd11, 32'h80000003);
    // back-to-back corner sweep; high lane uses a shifted pair
    for (int i = 0; i < NC; i++)
      for (int j = 0; j < NC; j++)
        step(1'b1, {corner[(i + 4) % NC], corner[i]},
             {corner[(j + 7) % NC], corner[j]}, 5'((i * NC + j) % 32),
             ((i + j) % 5 == 0) ? 32'h0000_0010 : 32'h1);
    // bubbles interleaved
    for (int i = 0; i < 20; i++)
      step(i[0], {corner[i % NC], corner[(i * 2) % NC]},
           {corner[(i * 5) % NC], corner[(i + 3) % NC]}, 5'(i), 32'h1);
    for (int i = 0; i < 2; i++) step(1'b0, '0, '0, '0, '0);
    // reset with operations in flight
    step(1'b1, 32'h00010001, 32'h00020002, 5'd3, 32'h1);
    step(1'b1, 32'h00010001, 32'h00020002, 5'd4, 32'h1);
    #1 rst_n = 1'b0;
    vld = 1'b0;
    @(negedge clk);
    chk(wr_en == 1'b0, "R8 flush in reset", {31'b0, wr_en}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    clear_hist();
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, '0);
    chk(wr_en == 1'b0, "R8 after release", {31'b0, wr_en}, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule